// File: doc/BRIEF.md
# Combined Enable/Pending Interrupt Aggregator

This block collects a small group of interrupt sources and presents them to a parent interrupt controller as one level-type request line. Software uses a single 32-bit register to control the block. The lower half of the register holds one enable bit per source. The upper half holds one pending bit per source. Each source's pending bit sits 16 positions above its enable bit, so one mask, shifted by 16, serves both halves.

Each source input first passes through a two-stage synchroniser. A rising edge on the synchronised signal latches the source's pending bit, whether or not the source is enabled. The request output is high while any source has both its pending bit and its enable bit set. A service routine clears each pending bit it has handled by writing 1 to that bit. Writing 0 to a pending bit leaves it as it is, so software can change the enables without losing events. The sources occupy a contiguous field that begins at a parameterised bit offset and has a parameterised width. Typical setups are offset 0 with 7 sources, offset 0 with 6 sources, and offset 4 with 2 sources.

Top module: `irqc_combined`

## Requirements
- R1: Enable bits sit at positions FIELD_LSB to FIELD_LSB+SRC_COUNT-1 of the register. A write loads them from the same positions of wdata, and a read returns them at those positions.
- R2: The pending bit of source i reads back at bit 16+FIELD_LSB+i. It sits 16 positions above that source's enable bit.
- R3: Writing 1 to a pending-bit position clears that pending bit on the clock edge of the write. Writing 0 there leaves the pending bit unchanged.
- R4: All bits outside the enable field and the pending field read as 0, and writes to them have no effect.
- R5: A 0-to-1 change on src[i] sets pending bit i whether or not source i is enabled. The bit is visible on rdata after the third rising clock edge that follows the input change.
- R6: If a source edge and a write-1-to-clear reach the same pending bit in the same cycle, the pending bit ends up set.
- R7: irq is 1 exactly when some source has both its pending bit and its enable bit set. irq stays high until every such pending bit has been cleared.
- R8: Setting the enable of a source whose pending bit is already set raises irq right after the enabling write's clock edge.
- R9: While rst_n is low at a rising clock edge, every enable bit and every pending bit is cleared, so rdata is 0 and irq is 0.
- R10: A source input that stays high sets its pending bit only once. After that bit is cleared, it stays clear until the input falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe, sampled at the rising edge |
| wdata | input | 32 | Write data: enables in the low half, pending clear mask in the high half |
| rdata | output | 32 | Register contents: enables in the low half, pending bits in the high half |
| src | input | SRC_COUNT | Asynchronous interrupt source inputs |
| irq | output | 1 | Combined level request to the parent controller |

## Verification
The checker verifies on every cycle that reserved bits stay zero, that irq matches the enabled pending bits seen on rdata, and that a write-1-to-clear empties the bits it names unless an edge arrives at the same moment. It also verifies that a detected edge always leaves its pending bit set, and that the register holds still when there is neither a write nor an edge. The bench scenarios show the parts that need a planned sequence of inputs:
- the three-edge latency through the synchroniser;
- that an edge latches while the source is disabled;
- that a later enable fires irq;
- that an edge and a clear aimed at the same bit in the same cycle leave the bit set;
- that a held-high input does not set its pending bit again;
- that a reset in the middle of a run clears everything.

// File: rtl/irqc_pkg.sv
// Package: shared constants for the combined enable/pending interrupt aggregator.
// Assumes a 32-bit register split into two 16-bit halves.
package irqc_pkg;
    localparam int REG_W    = 32;
    localparam int HALF_W   = REG_W / 2;
    localparam int PEND_OFS = HALF_W;   // pending bit sits this far above its enable bit
    localparam int SYNC_STAGES = 2;

    typedef logic [REG_W-1:0] reg_word_t;
endpackage

// File: rtl/irqc_sync_edge.sv
// Synchroniser and rising-edge detector for a vector of asynchronous sources.
// Assumes every bit is an independent slow level; emits a one-cycle pulse per 0->1 change.
module irqc_sync_edge #(
    parameter int WIDTH  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] rise
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;
    logic [WIDTH-1:0]             prev_q;

    // Shift the sampled inputs through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    // Hold the previous synchronised value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign rise = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/irqc_pend_bank.sv
// Pending-bit storage with write-1-to-clear and set-over-clear priority.
// Assumes clr_mask is already qualified by the write strobe.
module irqc_pend_bank #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_vec,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] pend
);
    logic [WIDTH-1:0] pend_q;

    // Clear the named bits first, then let any new edge set its bit
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_mask) | set_vec;
    end

    assign pend = pend_q;
endmodule

// File: rtl/irqc_enable_reg.sv
// Plain read/write storage for the per-source enable bits.
// Assumes wdata_field is already aligned to bit 0 of the source field.
module irqc_enable_reg #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wdata_field,
    output logic [WIDTH-1:0] en
);
    logic [WIDTH-1:0] en_q;

    // Load the enables on a write, otherwise keep them
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= wdata_field;
    end

    assign en = en_q;
endmodule

// File: rtl/irqc_combined.sv
// Top level: one register holds the enables (low half) and the pending bits
// (high half, write-1-to-clear). The request output is the OR of pending AND enable.
// Assumes FIELD_LSB + SRC_COUNT <= 16.
module irqc_combined
    import irqc_pkg::*;
#(
    parameter int FIELD_LSB = 0,
    parameter int SRC_COUNT = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wdata,
    output logic [REG_W-1:0]     rdata,
    input  logic [SRC_COUNT-1:0] src,
    output logic                 irq
);
    localparam int EN_LO   = FIELD_LSB;
    localparam int PEND_LO = FIELD_LSB + PEND_OFS;

    logic [SRC_COUNT-1:0] src_rise;
    logic [SRC_COUNT-1:0] en_bits;
    logic [SRC_COUNT-1:0] pend_bits;
    logic [SRC_COUNT-1:0] clr_mask;

    irqc_sync_edge #(.WIDTH(SRC_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(src), .rise(src_rise)
    );

    irqc_enable_reg #(.WIDTH(SRC_COUNT)) u_en (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wdata_field(wdata[EN_LO +: SRC_COUNT]), .en(en_bits)
    );

    // Qualify the clear mask with the write strobe
    always_comb begin
        clr_mask = wr_en ? wdata[PEND_LO +: SRC_COUNT] : '0;
    end

    irqc_pend_bank #(.WIDTH(SRC_COUNT)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_vec(src_rise),
        .clr_mask(clr_mask), .pend(pend_bits)
    );

    // Assemble the read word; reserved positions are tied to zero
    always_comb begin
        rdata = '0;
        rdata[EN_LO   +: SRC_COUNT] = en_bits;
        rdata[PEND_LO +: SRC_COUNT] = pend_bits;
    end

    // Level request: any source that is both pending and enabled
    assign irq = |(pend_bits & en_bits);
endmodule

// File: rtl/irqc_combined_chk.sv
// Checker for irqc_combined; attached through bind below.
// Assumes it observes the top-level ports plus the internal edge pulses.
module irqc_combined_chk
    import irqc_pkg::*;
#(
    parameter int FIELD_LSB = 0,
    parameter int SRC_COUNT = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [REG_W-1:0]     wdata,
    input logic [REG_W-1:0]     rdata,
    input logic                 irq,
    input logic [SRC_COUNT-1:0] src_rise
);
    localparam int PEND_LO = FIELD_LSB + PEND_OFS;
    localparam reg_word_t FIELD_MASK =
        reg_word_t'(((64'd1 << SRC_COUNT) - 64'd1) << FIELD_LSB);
    localparam reg_word_t LIVE_MASK = FIELD_MASK | (FIELD_MASK << PEND_OFS);

    wire [SRC_COUNT-1:0] rd_en   = rdata[FIELD_LSB +: SRC_COUNT];
    wire [SRC_COUNT-1:0] rd_pend = rdata[PEND_LO +: SRC_COUNT];
    wire [SRC_COUNT-1:0] wr_clr  = wdata[PEND_LO +: SRC_COUNT];

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~LIVE_MASK) == '0);                                        // R4
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(rd_en & rd_pend));                                         // R7
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && src_rise == '0) |=> (rd_pend & $past(wr_clr)) == '0);     // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rise != '0) |=> (rd_pend & $past(src_rise)) == $past(src_rise)); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && src_rise == '0) |=> $stable(rdata));                     // R1
endmodule

bind irqc_combined irqc_combined_chk #(.FIELD_LSB(FIELD_LSB), .SRC_COUNT(SRC_COUNT)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .irq(irq), .src_rise(src_rise)
);

// File: tb/irqc_combined_tb.sv
// Scoreboard bench: tasks push expected register/irq values, a monitor compares them.
module irqc_combined_tb;
    localparam int LSB = 2;
    localparam int N   = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [N-1:0]  src = '0;
    logic          irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] exp_rd_q[$];
    logic        exp_irq_q[$];
    string       exp_tag_q[$];

    irqc_combined #(.FIELD_LSB(LSB), .SRC_COUNT(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .src(src), .irq(irq)
    );

    always #2 clk = ~clk;   // 250 MHz

    // Monitor: pop each expected item and compare with the live outputs
    initial begin
        forever begin
            wait (exp_rd_q.size() > 0);
            checks++;
            if (rdata !== exp_rd_q[0] || irq !== exp_irq_q[0]) begin
                failures++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         exp_tag_q[0], rdata, irq, exp_rd_q[0], exp_irq_q[0]);
            end
            void'(exp_rd_q.pop_front());
            void'(exp_irq_q.pop_front());
            void'(exp_tag_q.pop_front());
        end
    end

    task automatic expect_state(input logic [31:0] rd, input logic ir, input string tag);
        exp_rd_q.push_back(rd);
        exp_irq_q.push_back(ir);
        exp_tag_q.push_back(tag);
        wait (exp_rd_q.size() == 0);
    endtask

    task automatic reg_write(input logic [31:0] d);
        wr_en = 1'b1;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        wdata = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_src(input int idx);
        src[idx] = 1'b1;
        @(negedge clk);
        src[idx] = 1'b0;
        idle(4);
    endtask

    initial begin
        idle(3);
        expect_state(32'h0, 1'b0, "R9 reset state");
        rst_n = 1'b1;
        @(negedge clk);

        reg_write(32'hFFFF_FFFF);
        expect_state(32'h0000_007C, 1'b0, "R1 R4 enables load, reserved ignored");
        reg_write(32'h0);
        expect_state(32'h0, 1'b0, "R1 enables cleared");

        // Edge detection latency: pending bit visible after the third edge
        src[0] = 1'b1;
        idle(2);
        expect_state(32'h0, 1'b0, "R5 not yet visible after two edges");
        idle(1);
        expect_state(32'h0004_0000, 1'b0, "R5 R2 pending while disabled");
        src[0] = 1'b0;
        idle(2);

        reg_write(32'h0000_0004);
        expect_state(32'h0004_0004, 1'b1, "R8 enable fires irq");
        reg_write(32'h0000_0004);
        expect_state(32'h0004_0004, 1'b1, "R3 write 0 keeps pending");
        reg_write(32'h0004_0004);
        expect_state(32'h0000_0004, 1'b0, "R3 write 1 clears");

        // Held-high source on a disabled line
        src[3] = 1'b1;
        idle(4);
        expect_state(32'h0020_0004, 1'b0, "R7 disabled pending gives no irq");
        reg_write(32'h0020_0004);
        idle(4);
        expect_state(32'h0000_0004, 1'b0, "R10 held level does not re-set");
        src[3] = 1'b0;
        idle(2);

        reg_write(32'h0000_007C);
        pulse_src(4);
        expect_state(32'h0040_007C, 1'b1, "R7 enabled pending raises irq");
        reg_write(32'h0040_007C);
        expect_state(32'h0000_007C, 1'b0, "R7 irq drops after clear");

        // Collision: edge and clear on the same bit in the same cycle
        pulse_src(1);
        expect_state(32'h0008_007C, 1'b1, "R5 second source pending");
        src[1] = 1'b1;
        idle(2);
        reg_write(32'h0008_007C);
        expect_state(32'h0008_007C, 1'b1, "R6 set wins over clear");
        src[1] = 1'b0;
        reg_write(32'h0008_007C);
        expect_state(32'h0000_007C, 1'b0, "R6 later clear works");

        reg_write(32'hFF83_FF83);
        expect_state(32'h0, 1'b0, "R4 reserved-only write");

        reg_write(32'h0000_007C);
        pulse_src(2);
        expect_state(32'h0010_007C, 1'b1, "R7 before reset");
        rst_n = 1'b0;
        @(negedge clk);
        expect_state(32'h0, 1'b0, "R9 mid-run reset");
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule